// File: doc/BRIEF.md
# Load/Store Effective-Address Unit

This unit forms the effective address for one load or store at a time inside an out-of-order core. A one-cycle issue pulse hands it an opcode, an immediate, an immediate-valid flag, a zero-base flag and an update flag. From the two flags it works out which register operands it still needs. It raises a read request for each of them, and it captures each operand in the cycle its grant arrives.

Once no request is outstanding, the unit presents the sum and raises an address-release line. That line stays up until the address phase is acknowledged. If neither operand is needed, the read phase is skipped and the address is released in the cycle right after issue. When the update flag was set, the same address is also offered as a writeback result.

Top module: `ldst_addr_unit`

## Requirements
- R1: An operation is accepted only on a cycle with `issue_i` high while the unit is idle. Opcode, immediate, immediate-valid, zero-base and update flags are captured then. Later changes on those inputs do not alter the operation, and `op_o` shows the captured opcode while busy.
- R2: The cycle after acceptance, `rd_rel_o` carries the request mask. Bit 0 requests the base operand and is 1 exactly when the zero-base flag was 0. Bit 1 requests the index operand and is 1 exactly when the immediate-valid flag was 0.
- R3: When the mask is 00, no read request is ever raised and `adr_rel_o` is 1 in the cycle right after acceptance.
- R4: The address `ea_o` is the base term plus the offset term, modulo 2^ADDR_W. The offset term is the immediate when immediate-valid was set, and the granted index operand otherwise. For example, base 4 plus index 5 gives 9, and 0xFFFF plus 2 gives 0x0001 at 16 bits.
- R5: With the zero-base flag set, the base term is 0. For example, an immediate of 9 yields address 9.
- R6: While `adr_rel_o` is high and the update flag was set, `wb_valid_o` is 1 and `wb_data_o` equals `ea_o`. Otherwise `wb_valid_o` is 0.
- R7: `adr_rel_o` stays high until a cycle with `adr_go_i` high. After that cycle it is 0 and the unit is idle. `adr_go_i` has no effect while `adr_rel_o` is low.
- R8: A grant bit in `rd_go_i` takes effect only while the same bit of `rd_rel_o` is high. On that cycle the matching operand (`base_i` for bit 0, `index_i` for bit 1) is captured, and the request bit is 0 in the next cycle. `adr_rel_o` rises in the cycle after the last outstanding bit is granted. Both bits may be granted in one cycle.
- R9: `busy_o` is 1 from the cycle after acceptance until the cycle after the address acknowledge. An issue pulse while busy is ignored, including one in the same cycle as the acknowledge.
- R10: A synchronous reset (`rst` high at a clock edge) clears `busy_o`, `rd_rel_o` and `adr_rel_o`, even in the middle of an operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue_i | input | 1 | One-cycle issue pulse |
| op_i | input | OP_W | Opcode of the issued operation |
| imm_i | input | ADDR_W | Immediate offset |
| imm_ok_i | input | 1 | Immediate replaces the index operand |
| zero_base_i | input | 1 | Base term forced to zero |
| update_i | input | 1 | Return the address for writeback |
| base_i | input | ADDR_W | Base operand from the register file |
| index_i | input | ADDR_W | Index operand from the register file |
| rd_go_i | input | 2 | Read grants (bit 0 base, bit 1 index) |
| rd_rel_o | output | 2 | Read requests (bit 0 base, bit 1 index) |
| adr_go_i | input | 1 | Address-phase acknowledge |
| adr_rel_o | output | 1 | Address ready and held |
| ea_o | output | ADDR_W | Effective address |
| op_o | output | OP_W | Captured opcode |
| wb_valid_o | output | 1 | Address offered for writeback |
| wb_data_o | output | ADDR_W | Writeback value |
| busy_o | output | 1 | Operation in flight |

## Verification
Two pairs of events can land on the same edge. The base and index grants can arrive together, and a new issue pulse can arrive in the cycle that acknowledges the address. The bench drives both grant bits at once in an indexed operation and checks that both operands land and that the release follows one cycle later. It also places an issue pulse exactly on the acknowledge cycle and checks that the unit ends up idle with no request raised. A behavioural model, which keeps its own integers and mask, is compared against every output on every clock.

// File: rtl/ldst_addr_pkg.sv
package ldst_addr_pkg;
  localparam int RD_LANES = 2;
  localparam int RD_BASE  = 0;
  localparam int RD_INDEX = 1;

  typedef logic [RD_LANES-1:0] rd_mask_t;

  // Which register operands must still be read for an operation.
  function automatic rd_mask_t rd_need(input logic zero_base, input logic imm_ok);
    rd_mask_t m;
    m[RD_BASE]  = ~zero_base;
    m[RD_INDEX] = ~imm_ok;
    return m;
  endfunction
endpackage

// File: rtl/ldst_rdgate.sv
module ldst_rdgate
  import ldst_addr_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     load_en,
  input  rd_mask_t load_mask,
  input  rd_mask_t go,
  output rd_mask_t rel,
  output rd_mask_t hit,
  output logic     drain
);
  rd_mask_t rel_q;

  assign hit   = go & rel_q;
  assign drain = (|rel_q) && ((rel_q & ~hit) == '0);
  assign rel   = rel_q;

  always_ff @(posedge clk) begin
    if (rst)          rel_q <= '0;
    else if (load_en) rel_q <= load_mask;
    else              rel_q <= rel_q & ~hit;
  end

  for (genvar g = 0; g < RD_LANES; g++) begin : g_lane_chk
    // R8: a granted request bit drops on the next cycle
    a_r8_grant_clears : assert property (@(posedge clk) disable iff (rst)
      rel_q[g] && go[g] |=> !rel_q[g]);
  end
endmodule

// File: rtl/ldst_opnd_cap.sv
module ldst_opnd_cap
  import ldst_addr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                           clk,
  input  logic                           preset_en,
  input  logic [RD_LANES-1:0][ADDR_W-1:0] preset_val,
  input  rd_mask_t                       cap_en,
  input  logic [RD_LANES-1:0][ADDR_W-1:0] cap_val,
  output logic [RD_LANES-1:0][ADDR_W-1:0] opnd
);
  for (genvar g = 0; g < RD_LANES; g++) begin : g_lane
    logic [ADDR_W-1:0] q;
    always_ff @(posedge clk) begin
      if (preset_en)      q <= preset_val[g];
      else if (cap_en[g]) q <= cap_val[g];
    end
    assign opnd[g] = q;
  end
endmodule

// File: rtl/ldst_agen.sv
module ldst_agen #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] offs,
  output logic [ADDR_W-1:0] ea
);
  // Sum that wraps at the adder width.
  function automatic logic [ADDR_W-1:0] ea_add(input logic [ADDR_W-1:0] a,
                                               input logic [ADDR_W-1:0] b);
    return a + b;
  endfunction

  assign ea = ea_add(base, offs);
endmodule

// File: rtl/ldst_addr_unit.sv
module ldst_addr_unit
  import ldst_addr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OP_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [ADDR_W-1:0] imm_i,
  input  logic              imm_ok_i,
  input  logic              zero_base_i,
  input  logic              update_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] index_i,
  input  logic [1:0]        rd_go_i,
  output logic [1:0]        rd_rel_o,
  input  logic              adr_go_i,
  output logic              adr_rel_o,
  output logic [ADDR_W-1:0] ea_o,
  output logic [OP_W-1:0]   op_o,
  output logic              wb_valid_o,
  output logic [ADDR_W-1:0] wb_data_o,
  output logic              busy_o
);
  logic      busy_q, adr_rel_q, upd_q;
  logic [OP_W-1:0] op_q;

  // Named internal events
  logic      accept;     // issue taken this cycle
  logic      skip_read;  // accepted with nothing to read
  logic      addr_done;  // address phase acknowledged
  rd_mask_t  need_mask;
  rd_mask_t  rd_hit;
  logic      rd_drain;   // last outstanding request granted this cycle
  logic [RD_LANES-1:0][ADDR_W-1:0] preset_v, cap_v, opnd;

  assign accept    = issue_i && !busy_q;
  assign need_mask = rd_need(zero_base_i, imm_ok_i);
  assign skip_read = accept && (need_mask == '0);
  assign addr_done = adr_rel_q && adr_go_i;

  ldst_rdgate u_rdgate (
    .clk      (clk),
    .rst      (rst),
    .load_en  (accept),
    .load_mask(need_mask),
    .go       (rd_go_i),
    .rel      (rd_rel_o),
    .hit      (rd_hit),
    .drain    (rd_drain)
  );

  // Base lane presets to zero; index lane presets to the immediate.
  assign preset_v[RD_BASE]  = '0;
  assign preset_v[RD_INDEX] = imm_i;
  assign cap_v[RD_BASE]     = base_i;
  assign cap_v[RD_INDEX]    = index_i;

  ldst_opnd_cap #(.ADDR_W(ADDR_W)) u_opnd (
    .clk       (clk),
    .preset_en (accept),
    .preset_val(preset_v),
    .cap_en    (rd_hit),
    .cap_val   (cap_v),
    .opnd      (opnd)
  );

  ldst_agen #(.ADDR_W(ADDR_W)) u_agen (
    .base(opnd[RD_BASE]),
    .offs(opnd[RD_INDEX]),
    .ea  (ea_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      adr_rel_q <= 1'b0;
    end else begin
      if (accept)         busy_q <= 1'b1;
      else if (addr_done) busy_q <= 1'b0;
      if (skip_read || rd_drain) adr_rel_q <= 1'b1;
      else if (addr_done)        adr_rel_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      op_q  <= op_i;
      upd_q <= update_i;
    end
  end

  assign busy_o     = busy_q;
  assign adr_rel_o  = adr_rel_q;
  assign op_o       = op_q;
  assign wb_valid_o = adr_rel_q && upd_q;
  assign wb_data_o  = ea_o;

  // R2: request mask follows the flags captured at issue
  a_r2_mask_from_flags : assert property (@(posedge clk) disable iff (rst)
    issue_i && !busy_o |=> rd_rel_o == {!$past(imm_ok_i), !$past(zero_base_i)});
  // R3: nothing to read means release right after issue
  a_r3_skip_read : assert property (@(posedge clk) disable iff (rst)
    issue_i && !busy_o && zero_base_i && imm_ok_i |=> adr_rel_o && rd_rel_o == 2'b00);
  // R6: writeback offered only during release
  a_r6_wb_in_release : assert property (@(posedge clk) disable iff (rst)
    wb_valid_o |-> adr_rel_o && wb_data_o == ea_o);
  // R7: release held without acknowledge
  a_r7_release_held : assert property (@(posedge clk) disable iff (rst)
    adr_rel_o && !adr_go_i |=> adr_rel_o && $stable(ea_o));
  // R7: acknowledge frees the unit
  a_r7_ack_frees : assert property (@(posedge clk) disable iff (rst)
    adr_rel_o && adr_go_i |=> !adr_rel_o && !busy_o && rd_rel_o == 2'b00);
  // R9: idle unit raises nothing
  a_r9_idle_quiet : assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> rd_rel_o == 2'b00 && !adr_rel_o);
  // R9: issue while busy leaves opcode untouched
  a_r9_busy_ignores_issue : assert property (@(posedge clk) disable iff (rst)
    busy_o && issue_i && !adr_go_i |=> busy_o && $stable(op_o));
  // R10: reset clears control state
  a_r10_reset_clears : assert property (@(posedge clk)
    rst |=> !busy_o && !adr_rel_o && rd_rel_o == 2'b00);
endmodule

// File: tb/sim_ldst_addr_unit.sv
module sim_ldst_addr_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue_i = 1'b0;
  logic [1:0]  op_i = '0;
  logic [15:0] imm_i = '0;
  logic        imm_ok_i = 1'b0;
  logic        zero_base_i = 1'b0;
  logic        update_i = 1'b0;
  logic [15:0] base_i = '0;
  logic [15:0] index_i = '0;
  logic [1:0]  rd_go_i = '0;
  logic        adr_go_i = 1'b0;
  logic [1:0]  rd_rel_o;
  logic        adr_rel_o, wb_valid_o, busy_o;
  logic [15:0] ea_o, wb_data_o;
  logic [1:0]  op_o;

  always #4 clk = ~clk;

  ldst_addr_unit #(.ADDR_W(16), .OP_W(2)) u0 (
    .clk(clk), .rst(rst), .issue_i(issue_i), .op_i(op_i), .imm_i(imm_i),
    .imm_ok_i(imm_ok_i), .zero_base_i(zero_base_i), .update_i(update_i),
    .base_i(base_i), .index_i(index_i), .rd_go_i(rd_go_i), .rd_rel_o(rd_rel_o),
    .adr_go_i(adr_go_i), .adr_rel_o(adr_rel_o), .ea_o(ea_o), .op_o(op_o),
    .wb_valid_o(wb_valid_o), .wb_data_o(wb_data_o), .busy_o(busy_o));

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit        m_busy, m_adr, m_upd;
  bit [1:0]  m_rel;
  bit [1:0]  m_op;
  int        m_base, m_idx;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_adr = 0; m_rel = 0;
    end else if (!m_busy) begin
      if (issue_i) begin
        m_busy = 1; m_op = op_i; m_upd = update_i;
        m_base = 0;
        m_idx  = imm_ok_i ? int'(imm_i) : 0;
        m_rel  = {!imm_ok_i, !zero_base_i};
        m_adr  = (m_rel == 2'b00);
      end
    end else if (m_rel != 0) begin
      if (rd_go_i[0] && m_rel[0]) begin m_base = int'(base_i);  m_rel[0] = 0; end
      if (rd_go_i[1] && m_rel[1]) begin m_idx  = int'(index_i); m_rel[1] = 0; end
      if (m_rel == 0) m_adr = 1;
    end else if (m_adr && adr_go_i) begin
      m_adr = 0; m_busy = 0;
    end
  end

  // Compare every clock, away from the edge
  always @(posedge clk) begin
    #2;
    if (!done) begin
      int exp_ea;
      exp_ea = (m_base + m_idx) % 65536;
      chk("R9 busy", busy_o == m_busy, busy_o, m_busy);
      chk("R8 rd_rel", rd_rel_o == m_rel, rd_rel_o, m_rel);
      chk("R7 adr_rel", adr_rel_o == m_adr, adr_rel_o, m_adr);
      if (m_adr) chk("R4 ea", int'(ea_o) == exp_ea, ea_o, exp_ea);
      chk("R6 wb_valid", wb_valid_o == (m_adr && m_upd), wb_valid_o, m_adr && m_upd);
      if (m_adr && m_upd) chk("R6 wb_data", int'(wb_data_o) == exp_ea, wb_data_o, exp_ea);
      if (m_busy) chk("R1 op", op_o == m_op, op_o, m_op);
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic issue(input logic [1:0] op, input logic [15:0] imm,
                       input bit iok, input bit zb, input bit upd);
    op_i = op; imm_i = imm; imm_ok_i = iok; zero_base_i = zb; update_i = upd;
    issue_i = 1'b1;
    tick();
    issue_i = 1'b0;
    // R1: scramble operation inputs after acceptance
    op_i = ~op; imm_i = 16'hDEAD; imm_ok_i = !iok; zero_base_i = !zb; update_i = !upd;
  endtask

  task automatic grant(input logic [1:0] go, input logic [15:0] b, input logic [15:0] x);
    rd_go_i = go; base_i = b; index_i = x;
    tick();
    rd_go_i = '0; base_i = 16'hBEEF; index_i = 16'hF00D;
  endtask

  task automatic ack();
    adr_go_i = 1'b1;
    tick();
    adr_go_i = 1'b0;
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R10: reset state
    chk("R10 reset idle", !busy_o && !adr_rel_o && rd_rel_o == 0, {busy_o, adr_rel_o, rd_rel_o}, 0);

    // Indexed form, both grants together, update set: 4 + 5 = 9
    issue(2'd1, 16'h0, 0, 0, 1);
    chk("R2 mask 11", rd_rel_o == 2'b11, rd_rel_o, 2'b11);
    grant(2'b11, 16'd4, 16'd5);
    chk("R8 release after grant", adr_rel_o == 1, adr_rel_o, 1);
    chk("R4 indexed 9", ea_o == 16'd9, ea_o, 9);
    chk("R6 wb 9", wb_valid_o && wb_data_o == 16'd9, wb_data_o, 9);
    tick(); tick();
    chk("R7 held", adr_rel_o == 1, adr_rel_o, 1);
    ack();
    chk("R7 freed", !adr_rel_o && !busy_o, {adr_rel_o, busy_o}, 0);

    // Zero base plus immediate 9: read phase skipped
    issue(2'd2, 16'd9, 1, 1, 0);
    chk("R3 skip read", adr_rel_o && rd_rel_o == 0, {adr_rel_o, rd_rel_o}, 4);
    chk("R5 zero base 9", ea_o == 16'd9, ea_o, 9);
    ack();

    // Base plus immediate; spurious index grant ignored; ack during read ignored
    issue(2'd3, 16'h0010, 1, 0, 1);
    chk("R2 mask 01", rd_rel_o == 2'b01, rd_rel_o, 1);
    adr_go_i = 1'b1;
    grant(2'b10, 16'h1111, 16'h2222);
    adr_go_i = 1'b0;
    chk("R8 unrequested grant ignored", rd_rel_o == 2'b01 && busy_o, rd_rel_o, 1);
    grant(2'b01, 16'h0020, 16'h3333);
    chk("R4 base+imm", ea_o == 16'h0030, ea_o, 16'h30);
    ack();

    // Zero base with index register, index granted late
    issue(2'd0, 16'h0, 0, 1, 0);
    chk("R2 mask 10", rd_rel_o == 2'b10, rd_rel_o, 2);
    tick();
    grant(2'b10, 16'h5555, 16'd7);
    chk("R5 zero base index 7", ea_o == 16'd7, ea_o, 7);
    ack();

    // Wraparound, grants in separate cycles, index first
    issue(2'd1, 16'h0, 0, 0, 1);
    grant(2'b10, 16'h0, 16'd2);
    chk("R8 base still pending", rd_rel_o == 2'b01 && !adr_rel_o, rd_rel_o, 1);
    grant(2'b01, 16'hFFFF, 16'h0);
    chk("R4 wrap", ea_o == 16'h0001, ea_o, 1);
    // R9: issue while busy, then issue on the acknowledge cycle
    issue(2'd3, 16'd100, 1, 1, 0);
    chk("R9 issue while busy ignored", ea_o == 16'h0001 && op_o == 2'd1, ea_o, 1);
    adr_go_i = 1'b1; issue_i = 1'b1; imm_ok_i = 1'b1; zero_base_i = 1'b1;
    tick();
    adr_go_i = 1'b0; issue_i = 1'b0;
    tick();
    chk("R9 issue on ack ignored", !busy_o && !adr_rel_o, {busy_o, adr_rel_o}, 0);

    // R10: reset mid-operation
    issue(2'd2, 16'h0, 0, 0, 0);
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk("R10 reset mid-op", !busy_o && rd_rel_o == 0, {busy_o, rd_rel_o}, 0);
    tick();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      vectors++; misses++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule